// File: doc/BRIEF.md
# Asynchronous SRAM Write Bus Controller

This block turns single write requests from a synchronous core into the strobe sequence that an asynchronous memory bank (SRAM or flash) expects. A request carries a bank index, an address, a data word and per-byte enables. It is taken over a valid/ready handshake, registered, and then played out on the external pins as three phases: setup, write-access and hold. Each phase lasts a programmable number of system clock cycles.

New accesses may start only on a fixed issue grid of `SLOT` cycles (5 by default), counted from reset. The grid lets the select pin of a bank stay low across two consecutive writes to that bank when the phases fill a slot exactly. When the phases are shorter than the slot, the select pin goes high in the gap. A turnaround count sets the minimum number of all-deselected cycles required before a write to a different bank may start. A write to the same bank waits for no turnaround.

Top module: `asram_wr_ctrl`

## Requirements
- R1: `req_ready` is high only in the last cycle of a slot, which is the cycle whose index since reset release is `SLOT-1` modulo `SLOT`. It is high in such a cycle whenever no access continues into the next cycle and the turnaround rule (R8) allows the pending bank. A request accepted in that cycle starts its access in the next cycle.
- R2: In the first cycle of an access, exactly the selected bank's bit of `mem_sel_n` is low, and all other bits are high. `mem_addr`, `mem_data` and `mem_be_n` show the request in that same cycle, with `mem_be_n` equal to the inverted byte enables.
- R3: `mem_we_n` is high for the setup cycles, then low for exactly the access count, starting at cycle index equal to the setup count within the access.
- R4: After `mem_we_n` rises, the bank stays selected for exactly the hold count. With a hold count of 0, the access ends in the cycle in which `mem_we_n` is last low.
- R5: A setup or access count programmed as 0 behaves as 1. Hold and turnaround counts of 0 are honoured as 0.
- R6: When no access is in progress, all bits of `mem_sel_n` and `mem_we_n` are high. This includes the gap left when setup+access+hold is shorter than the slot.
- R7: When setup+access+hold equals the slot length and the next request to the same bank is accepted at once, that bank's select stays low without a break from the old access into the new one.
- R8: A request to a bank other than the previous one is not accepted unless the number of all-deselected cycles before its start would be at least the turnaround count.
- R9: When setup+access+hold exceeds the slot length, the next access starts at the first slot boundary after the current one ends.
- R10: The address, data and byte-enable outputs hold the accepted values for the whole access, even when the request inputs change.
- R11: During and after reset, until the first access, every select bit and `mem_we_n` are high, `mem_addr` and `mem_data` are zero, and `mem_be_n` is all ones.
- R12: The timing counts are captured when a request is accepted. Changing them during an access does not alter that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core has a write request |
| req_ready | output | 1 | Request accepted on this cycle's rising edge when valid |
| req_bank | input | BANK_W | Target bank index |
| req_addr | input | ADDR_W | Write address |
| req_data | input | DATA_W | Write data |
| req_be | input | BE_W | Byte enables, active high |
| cfg_setup | input | CNT_W | Setup cycle count |
| cfg_access | input | CNT_W | Write-access cycle count |
| cfg_hold | input | CNT_W | Hold cycle count |
| cfg_turn | input | CNT_W | Turnaround cycles between different banks |
| mem_sel_n | output | NBANK | Bank selects, active low |
| mem_addr | output | ADDR_W | Address bus |
| mem_data | output | DATA_W | Write data bus |
| mem_be_n | output | BE_W | Byte enables, active low |
| mem_we_n | output | 1 | Write enable, active low |

## Verification
The bench goes after a phase sum of exactly one slot to the same bank. A design that wrongly drops the select there shows a one-cycle high pulse on `mem_sel_n`. It also covers a sum shorter than the slot, where a design that held the select would leave the bank selected through the gap. A hold of zero and setup/access counts of zero are covered too, where off-by-one phase counters would stretch or lose a strobe cycle. Turnaround between banks is checked just below and just above the free gap, where a wrong comparison would admit a request one slot early or late. A sum longer than the slot must push the next start to a later slot boundary. Changing the timing inputs and request fields in the middle of an access would expose a design that did not register them.

// File: rtl/asram_wr_pkg.sv
package asram_wr_pkg;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_SETUP  = 2'd1,
      PH_ACCESS = 2'd2,
      PH_HOLD   = 2'd3
   } wr_phase_e;

endpackage

// File: rtl/wr_slot_timer.sv
module wr_slot_timer #(
   parameter int SLOT = 5,
   localparam int SW = (SLOT > 1) ? $clog2(SLOT) : 1
) (
   input  logic clk,
   input  logic rst_n,
   output logic slot_last
);
   logic [SW-1:0] slot_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         slot_q <= '0;
      else if (slot_q == SW'(SLOT - 1))
         slot_q <= '0;
      else
         slot_q <= slot_q + 1'b1;
   end

   assign slot_last = (slot_q == SW'(SLOT - 1));
endmodule

// File: rtl/wr_access_engine.sv
module wr_access_engine
   import asram_wr_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] t_setup,
   input  logic [CNT_W-1:0] t_access,
   input  logic [CNT_W-1:0] t_hold,
   output logic             active,
   output logic             strobe,
   output logic             last
);
   wr_phase_e        ph_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] acc_q;
   logic [CNT_W-1:0] hold_q;
   logic [CNT_W-1:0] s_eff;
   logic [CNT_W-1:0] a_eff;

   assign s_eff = (t_setup == '0) ? CNT_W'(1) : t_setup;
   assign a_eff = (t_access == '0) ? CNT_W'(1) : t_access;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= PH_IDLE;
         cnt_q  <= '0;
         acc_q  <= CNT_W'(1);
         hold_q <= '0;
      end else if (start) begin
         ph_q   <= PH_SETUP;
         cnt_q  <= s_eff - 1'b1;
         acc_q  <= a_eff;
         hold_q <= t_hold;
      end else begin
         unique case (ph_q)
            PH_SETUP: begin
               if (cnt_q == '0) begin
                  ph_q  <= PH_ACCESS;
                  cnt_q <= acc_q - 1'b1;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            PH_ACCESS: begin
               if (cnt_q == '0) begin
                  if (hold_q == '0) begin
                     ph_q <= PH_IDLE;
                  end else begin
                     ph_q  <= PH_HOLD;
                     cnt_q <= hold_q - 1'b1;
                  end
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            PH_HOLD: begin
               if (cnt_q == '0)
                  ph_q <= PH_IDLE;
               else
                  cnt_q <= cnt_q - 1'b1;
            end
            default: ph_q <= PH_IDLE;
         endcase
      end
   end

   assign active = (ph_q != PH_IDLE);
   assign strobe = (ph_q == PH_ACCESS);
   assign last   = ((ph_q == PH_ACCESS) && (cnt_q == '0) && (hold_q == '0)) ||
                   ((ph_q == PH_HOLD) && (cnt_q == '0));
endmodule

// File: rtl/wr_gap_tracker.sv
module wr_gap_tracker #(
   parameter int CNT_W  = 4,
   parameter int BANK_W = 2,
   localparam int GW = CNT_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              busy,
   input  logic              accept,
   input  logic [BANK_W-1:0] req_bank,
   input  logic [CNT_W-1:0]  turn,
   output logic              bank_ok
);
   logic [GW-1:0]     idle_q;
   logic [GW-1:0]     gap_now;
   logic [BANK_W-1:0] prev_bank_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         idle_q <= '1;
      else if (busy)
         idle_q <= '0;
      else if (idle_q != '1)
         idle_q <= idle_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         prev_bank_q <= '0;
      else if (accept)
         prev_bank_q <= req_bank;
   end

   always_comb begin
      if (busy)
         gap_now = '0;
      else if (idle_q == '1)
         gap_now = idle_q;
      else
         gap_now = idle_q + 1'b1;
   end

   assign bank_ok = (req_bank == prev_bank_q) || (gap_now >= {1'b0, turn});
endmodule

// File: rtl/asram_wr_ctrl.sv
module asram_wr_ctrl #(
   parameter int ADDR_W = 24,
   parameter int DATA_W = 32,
   parameter int NBANK  = 4,
   parameter int CNT_W  = 4,
   parameter int SLOT   = 5,
   localparam int BE_W   = DATA_W / 8,
   localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [BANK_W-1:0] req_bank,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_data,
   input  logic [BE_W-1:0]   req_be,
   input  logic [CNT_W-1:0]  cfg_setup,
   input  logic [CNT_W-1:0]  cfg_access,
   input  logic [CNT_W-1:0]  cfg_hold,
   input  logic [CNT_W-1:0]  cfg_turn,
   output logic [NBANK-1:0]  mem_sel_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_data,
   output logic [BE_W-1:0]   mem_be_n,
   output logic              mem_we_n
);
   generate
      if (DATA_W % 8 != 0) begin : g_bad_data_w
         $error("DATA_W must be a multiple of 8");
      end
      if (SLOT < 2) begin : g_bad_slot
         $error("SLOT must be at least 2");
      end
      if (NBANK < 1) begin : g_bad_nbank
         $error("NBANK must be at least 1");
      end
   endgenerate

   logic              slot_last;
   logic              busy;
   logic              strobe;
   logic              last;
   logic              bank_ok;
   logic              accept;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic [BE_W-1:0]   be_q;
   logic [BANK_W-1:0] bank_q;

   wr_slot_timer #(.SLOT(SLOT)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .slot_last (slot_last)
   );

   wr_access_engine #(.CNT_W(CNT_W)) u_eng (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (accept),
      .t_setup  (cfg_setup),
      .t_access (cfg_access),
      .t_hold   (cfg_hold),
      .active   (busy),
      .strobe   (strobe),
      .last     (last)
   );

   wr_gap_tracker #(.CNT_W(CNT_W), .BANK_W(BANK_W)) u_gap (
      .clk      (clk),
      .rst_n    (rst_n),
      .busy     (busy),
      .accept   (accept),
      .req_bank (req_bank),
      .turn     (cfg_turn),
      .bank_ok  (bank_ok)
   );

   assign req_ready = slot_last && (!busy || last) && bank_ok;
   assign accept    = req_valid && req_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         data_q <= '0;
         be_q   <= '0;
         bank_q <= '0;
      end else if (accept) begin
         addr_q <= req_addr;
         data_q <= req_data;
         be_q   <= req_be;
         bank_q <= req_bank;
      end
   end

   assign mem_addr = addr_q;
   assign mem_data = data_q;
   assign mem_be_n = ~be_q;
   assign mem_we_n = ~strobe;

   generate
      if (NBANK == 1) begin : g_single
         assign mem_sel_n[0] = ~busy;
      end else begin : g_multi
         for (genvar b = 0; b < NBANK; b++) begin : g_sel
            assign mem_sel_n[b] = ~(busy && (bank_q == BANK_W'(b)));
         end
      end
   endgenerate
endmodule

// File: rtl/asram_wr_ctrl_chk.sv
module asram_wr_ctrl_chk #(
   parameter int ADDR_W = 24,
   parameter int NBANK  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              slot_last,
   input logic [NBANK-1:0]  mem_sel_n,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_we_n
);
   assert_ready_on_grid_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> slot_last);

   assert_one_bank_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~mem_sel_n));

   assert_starts_in_setup_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (mem_we_n && !(&mem_sel_n)));

   assert_strobe_inside_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> !(&mem_sel_n));

   assert_addr_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!(&mem_sel_n) && !$past(req_valid && req_ready)) |-> $stable(mem_addr));
endmodule

bind asram_wr_ctrl asram_wr_ctrl_chk #(.ADDR_W(ADDR_W), .NBANK(NBANK)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .slot_last (slot_last),
   .mem_sel_n (mem_sel_n),
   .mem_addr  (mem_addr),
   .mem_we_n  (mem_we_n)
);

// File: tb/asram_wr_ctrl_bench.sv
`timescale 1ns/1ps
module asram_wr_ctrl_bench;
   localparam int ADDR_W = 24;
   localparam int DATA_W = 32;
   localparam int NBANK  = 4;
   localparam int CNT_W  = 4;
   localparam int SLOT   = 5;
   localparam int BE_W   = DATA_W / 8;
   localparam int BANK_W = 2;
   localparam int NVEC   = 8;

   // {setup, access, hold, turn, bank of first write, bank of second write}
   localparam logic [19:0] VECS [NVEC] = '{
      {4'd1, 4'd2, 4'd2, 4'd1, 2'd0, 2'd0},
      {4'd1, 4'd2, 4'd0, 4'd1, 2'd0, 2'd0},
      {4'd0, 4'd0, 4'd0, 4'd0, 2'd1, 2'd1},
      {4'd2, 4'd3, 4'd4, 4'd0, 2'd2, 2'd2},
      {4'd1, 4'd2, 4'd2, 4'd0, 2'd0, 2'd1},
      {4'd1, 4'd2, 4'd2, 4'd3, 2'd0, 2'd1},
      {4'd1, 4'd1, 4'd1, 4'd2, 2'd3, 2'd2},
      {4'd1, 4'd1, 4'd1, 4'd3, 2'd3, 2'd2}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_ready;
   logic [BANK_W-1:0] req_bank = '0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [DATA_W-1:0] req_data = '0;
   logic [BE_W-1:0]   req_be = '0;
   logic [CNT_W-1:0]  cfg_setup = 4'd1;
   logic [CNT_W-1:0]  cfg_access = 4'd1;
   logic [CNT_W-1:0]  cfg_hold = 4'd1;
   logic [CNT_W-1:0]  cfg_turn = 4'd0;
   logic [NBANK-1:0]  mem_sel_n;
   logic [ADDR_W-1:0] mem_addr;
   logic [DATA_W-1:0] mem_data;
   logic [BE_W-1:0]   mem_be_n;
   logic              mem_we_n;

   int n_checks = 0;
   int n_fail = 0;
   int cyc = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   asram_wr_ctrl u_asram_wr_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_ready  (req_ready),
      .req_bank   (req_bank),
      .req_addr   (req_addr),
      .req_data   (req_data),
      .req_be     (req_be),
      .cfg_setup  (cfg_setup),
      .cfg_access (cfg_access),
      .cfg_hold   (cfg_hold),
      .cfg_turn   (cfg_turn),
      .mem_sel_n  (mem_sel_n),
      .mem_addr   (mem_addr),
      .mem_data   (mem_data),
      .mem_be_n   (mem_be_n),
      .mem_we_n   (mem_we_n)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s at cycle %0d: actual 0x%0h expected 0x%0h", tag, cyc, act, exp);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   // Reference model of the requirements, evaluated between edges
   int act_k = -1;
   int e_s, e_a, e_h, e_t;
   int e_bank;
   logic [ADDR_W-1:0] e_addr;
   logic [DATA_W-1:0] e_data;
   logic [BE_W-1:0]   e_be;
   int idle_b = 1000;
   int prev_bank = 0;

   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic [NBANK-1:0] exp_sel;
         bit exp_we_n, free_b, exp_rdy;
         int gap_b, s_in, a_in;
         if (act_k >= 0) begin
            exp_sel = ~(NBANK'(1) << e_bank);
            exp_we_n = !(act_k >= e_s && act_k < e_s + e_a);
            chk(mem_sel_n == exp_sel, "R2/R4/R7/R9 select", mem_sel_n, exp_sel);
            chk(mem_we_n == exp_we_n, "R3/R4/R5/R12 write enable", mem_we_n, exp_we_n);
            chk(mem_addr == e_addr, "R2/R10 address", mem_addr, e_addr);
            chk(mem_data == e_data, "R2/R10 data", mem_data, e_data);
            chk(mem_be_n == ~e_be, "R2/R10 byte enables", mem_be_n, ~e_be);
         end else begin
            chk(mem_sel_n == '1, "R6 idle select", mem_sel_n, {NBANK{1'b1}});
            chk(mem_we_n == 1'b1, "R6 idle write enable", mem_we_n, 1);
         end
         free_b = (act_k < 0) || (act_k == e_t - 1);
         gap_b  = (act_k >= 0) ? 0 : idle_b + 1;
         exp_rdy = ((cyc % SLOT) == SLOT - 1) && free_b &&
                   ((int'(req_bank) == prev_bank) || (gap_b >= int'(cfg_turn)));
         if (req_valid)
            chk(req_ready == exp_rdy, "R1/R8/R9 ready", req_ready, exp_rdy);
         if (act_k >= 0) idle_b = 0;
         else if (idle_b < 1000) idle_b++;
         if (act_k >= 0) begin
            act_k++;
            if (act_k == e_t) act_k = -1;
         end
         if (req_valid && req_ready) begin
            s_in = (cfg_setup == 0) ? 1 : int'(cfg_setup);
            a_in = (cfg_access == 0) ? 1 : int'(cfg_access);
            e_s = s_in;
            e_a = a_in;
            e_h = int'(cfg_hold);
            e_t = e_s + e_a + e_h;
            e_bank = int'(req_bank);
            e_addr = req_addr;
            e_data = req_data;
            e_be = req_be;
            prev_bank = int'(req_bank);
            act_k = 0;
         end
      end
   end

   task automatic send(input int bank, input logic [ADDR_W-1:0] a,
                       input logic [DATA_W-1:0] d, input logic [BE_W-1:0] be);
      int waited = 0;
      req_bank = BANK_W'(bank);
      req_addr = a;
      req_data = d;
      req_be = be;
      req_valid = 1'b1;
      @(negedge clk);
      while (!req_ready && waited < 60) begin
         waited++;
         @(negedge clk);
      end
      chk(req_ready, "R1 request eventually accepted", req_ready, 1);
      @(posedge clk);
      #1;
      req_valid = 1'b0;
      req_addr = ~a;
      req_data = ~d;
      req_be = ~be;
   endtask

   task automatic settle();
      repeat (14) @(posedge clk);
      #1;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run did not finish, actual hung expected done");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(mem_sel_n == '1, "R11 reset select", mem_sel_n, {NBANK{1'b1}});
      chk(mem_we_n == 1'b1, "R11 reset write enable", mem_we_n, 1);
      chk(mem_addr == '0, "R11 reset address", mem_addr, 0);
      chk(mem_data == '0, "R11 reset data", mem_data, 0);
      chk(mem_be_n == '1, "R11 reset byte enables", mem_be_n, {BE_W{1'b1}});
      @(posedge clk);
      #1;
      rst_n = 1'b1;
      repeat (2) @(posedge clk);
      #1;

      // Table walk: two back-to-back writes per vector, model checks every cycle
      for (int v = 0; v < NVEC; v++) begin
         cfg_setup  = VECS[v][19:16];
         cfg_access = VECS[v][15:12];
         cfg_hold   = VECS[v][11:8];
         cfg_turn   = VECS[v][7:4];
         send(int'(VECS[v][3:2]), ADDR_W'(24'h100 + v), 32'hA5000000 + v, 4'b0101);
         send(int'(VECS[v][1:0]), ADDR_W'(24'h200 + v), 32'h5A000000 + v, 4'b1110);
         settle();
      end

      // R12: timing changed right after acceptance must not affect the running access
      cfg_setup = 4'd1; cfg_access = 4'd1; cfg_hold = 4'd1; cfg_turn = 4'd0;
      send(1, 24'hABCDE, 32'hDEADBEEF, 4'b1111);
      cfg_setup = 4'd3; cfg_access = 4'd3; cfg_hold = 4'd3;
      settle();

      // R4/R7: hold of zero with a slot-filling sum (2+3+0) keeps the select low
      cfg_setup = 4'd2; cfg_access = 4'd3; cfg_hold = 4'd0; cfg_turn = 4'd0;
      send(2, 24'h31, 32'h11111111, 4'b0011);
      send(2, 24'h32, 32'h22222222, 4'b1100);
      send(2, 24'h33, 32'h33333333, 4'b1000);
      settle();

      // R8: turnaround at the maximum pushes a bank switch several slots out
      cfg_setup = 4'd1; cfg_access = 4'd1; cfg_hold = 4'd0; cfg_turn = 4'd15;
      send(0, 24'h41, 32'h44444444, 4'b0001);
      send(3, 24'h42, 32'h55555555, 4'b0010);
      settle();

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule